// File: doc/BRIEF.md
# Nibble-Addressed Control Latch Bus

This block connects a processor-side register port to three narrow control buses and to the latch banks behind them. Each bus addresses one of 16 latches with a 4-bit address, moves one 4-bit nibble per transfer, and fires the transfer with a single enable strobe. The radio bus has its own address and data lines and one enable. The two audio buses share one address/data pair and are told apart only by their separate enables. Together the three banks hold 192 control bits, and the contents of every bank are brought out as flat vectors for the functions they steer.

The processor stages a command by writing a latch address and a nibble into the command register. It then writes the control register with a bus select and a direction bit, which starts a four-phase sequence. The phases are setup, strobe, hold and idle. A read copies the addressed latch into a readback field of the status register. A command attempted during a sequence is dropped and leaves a sticky overrun flag. When the remote-control mode input is high, only accesses marked as coming from the remote source are accepted.

Top module: `ctl_latch_bus`

## Requirements
- R1: Register select 0 is the command register. Bits [3:0] hold the latch address and bits [7:4] hold the data nibble. A write is accepted only when no transfer is running, and reading select 0 returns the stored byte.
- R2: Writing register select 1 starts a transfer. Bits [1:0] choose the bus: 0 is the radio bus, 1 is audio bus 1 and 2 is audio bus 2. Bit 2 is 1 for a read and 0 for a write. A bus code of 3 starts nothing, and busy stays 0.
- R3: A transfer started by the write accepted at clock edge E drives address and data from the cycle after E. The selected enable is high for exactly the second cycle after E. Address and data stay unchanged through the following cycle. Busy is 1 for those three cycles and 0 afterwards.
- R4: A write transfer stores the nibble into the addressed latch of the selected bank at the end of the strobe cycle. No bank latch changes without its enable.
- R5: The audio buses share one address/data pair. At most one enable is high in any cycle, and a transfer to one audio bank never alters the other, even at the same address.
- R6: A read transfer places the addressed latch's nibble in status bits [7:4] from the cycle after the strobe, and it leaves the latch unchanged.
- R7: After reset, every latch of all three banks is 0, all enables are 0, and the status register reads 0.
- R8: A write to register select 0 or 1 while busy is ignored and sets the overrun flag in status bit 1. Any write to register select 2 clears that flag.
- R9: While remote mode is high, accesses with the remote-source input low are ignored. Accesses marked remote are processed normally.
- R10: Register select 2 reads status: bit 0 is busy, bit 1 is overrun, and bits [7:4] hold the readback nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| remote_mode | input | 1 | High: accept only remote-marked accesses |
| cpu_remote | input | 1 | Marks the current access as coming from the remote source |
| cpu_wr | input | 1 | Register write strobe, one cycle per write |
| cpu_reg | input | 2 | Register select: 0 command, 1 control, 2 status |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for the selected register |
| rf_addr | output | 4 | Radio bus latch address |
| rf_data | output | 4 | Radio bus data nibble |
| rf_en | output | 1 | Radio bus enable strobe |
| af_addr | output | 4 | Shared audio bus latch address |
| af_data | output | 4 | Shared audio bus data nibble |
| af1_en | output | 1 | Audio bus 1 enable strobe |
| af2_en | output | 1 | Audio bus 2 enable strobe |
| rf_latch | output | 64 | Radio bank contents, latch i at bits [4i+3:4i] |
| af1_latch | output | 64 | Audio bank 1 contents, same layout |
| af2_latch | output | 64 | Audio bank 2 contents, same layout |

## Verification
The bench builds the block with its default 4-bit address and 4-bit nibble widths, so each bank has 16 latches and the full 8-bit register layout is exercised. With these values the top address 15 and address 0 are both reachable. The same address can also be written in both audio banks, which exposes any leakage across the shared address/data pair. Writes at the busy boundary, a bus code of 3, and remote-mode filtering are driven directly at the register port.

// File: rtl/ctl_bus_pkg.sv
package ctl_bus_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETUP  = 2'd1,
    SEQ_STROBE = 2'd2,
    SEQ_HOLD   = 2'd3
  } seq_state_e;

  localparam logic [1:0] BUS_RF   = 2'd0;
  localparam logic [1:0] BUS_AF1  = 2'd1;
  localparam logic [1:0] BUS_AF2  = 2'd2;
  localparam logic [1:0] BUS_NONE = 2'd3;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
endpackage

// File: rtl/ctl_latch_bank.sv
module ctl_latch_bank #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               stb,
  input  logic                               wr,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [DATA_W-1:0]                  rdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0]      flat
);
  localparam int NLAT = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [NLAT];

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    logic hit;
    assign hit = stb && wr && (addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[i] <= '0;
      else if (hit) mem_q[i] <= wdata;
    end
    assign flat[i*DATA_W +: DATA_W] = mem_q[i];
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/ctl_bus_seq.sv
module ctl_bus_seq
  import ctl_bus_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  localparam int REG_W = ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              remote_mode,
  input  logic              cpu_remote,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_reg,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic [DATA_W-1:0] rf_rd,
  input  logic [DATA_W-1:0] af1_rd,
  input  logic [DATA_W-1:0] af2_rd,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic [ADDR_W-1:0] af_addr,
  output logic [DATA_W-1:0] af_data,
  output logic [2:0]        stb,
  output logic              wr_op,
  output logic              busy
);
  seq_state_e        state_q, state_d;
  logic [REG_W-1:0]  cmd_q, cmd_d;
  logic [2:0]        ctrl_q, ctrl_d;
  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] rb_q, rb_d;
  logic [ADDR_W-1:0] rfa_q, rfa_d, afa_q, afa_d;
  logic [DATA_W-1:0] rfd_q, rfd_d, afd_q, afd_d;
  logic              accept, launch;
  logic [DATA_W-1:0] sel_rd;

  assign busy   = (state_q != SEQ_IDLE);
  assign accept = cpu_wr && (!remote_mode || cpu_remote);
  assign launch = accept && !busy && (cpu_reg == REG_CTRL) && (cpu_wdata[1:0] != BUS_NONE);

  always_comb begin
    case (ctrl_q[1:0])
      BUS_RF:  sel_rd = rf_rd;
      BUS_AF1: sel_rd = af1_rd;
      default: sel_rd = af2_rd;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    ctrl_d  = ctrl_q;
    ovr_d   = ovr_q;
    rb_d    = rb_q;
    rfa_d   = rfa_q;
    rfd_d   = rfd_q;
    afa_d   = afa_q;
    afd_d   = afd_q;
    if (accept) begin
      if (cpu_reg == REG_STAT) ovr_d = 1'b0;
      else if (cpu_reg == REG_CMD || cpu_reg == REG_CTRL) begin
        if (busy) ovr_d = 1'b1;
        else if (cpu_reg == REG_CMD) cmd_d = cpu_wdata;
        else ctrl_d = cpu_wdata[2:0];
      end
    end
    case (state_q)
      SEQ_IDLE: if (launch) begin
        state_d = SEQ_SETUP;
        if (cpu_wdata[1:0] == BUS_RF) begin
          rfa_d = cmd_q[ADDR_W-1:0];
          rfd_d = cmd_q[REG_W-1:ADDR_W];
        end else begin
          afa_d = cmd_q[ADDR_W-1:0];
          afd_d = cmd_q[REG_W-1:ADDR_W];
        end
      end
      SEQ_SETUP:  state_d = SEQ_STROBE;
      SEQ_STROBE: begin
        state_d = SEQ_HOLD;
        if (ctrl_q[2]) rb_d = sel_rd;
      end
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cmd_q   <= '0;
      ctrl_q  <= '0;
      ovr_q   <= 1'b0;
      rb_q    <= '0;
      rfa_q   <= '0;
      rfd_q   <= '0;
      afa_q   <= '0;
      afd_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ctrl_q  <= ctrl_d;
      ovr_q   <= ovr_d;
      rb_q    <= rb_d;
      rfa_q   <= rfa_d;
      rfd_q   <= rfd_d;
      afa_q   <= afa_d;
      afd_q   <= afd_d;
    end
  end

  for (genvar b = 0; b < 3; b++) begin : g_stb
    assign stb[b] = (state_q == SEQ_STROBE) && (ctrl_q[1:0] == 2'(b));
  end

  assign wr_op   = !ctrl_q[2];
  assign rf_addr = rfa_q;
  assign rf_data = rfd_q;
  assign af_addr = afa_q;
  assign af_data = afd_q;

  always_comb begin
    case (cpu_reg)
      REG_CMD:  cpu_rdata = cmd_q;
      REG_CTRL: cpu_rdata = {{(REG_W-3){1'b0}}, ctrl_q};
      REG_STAT: cpu_rdata = {rb_q, {(REG_W-DATA_W-2){1'b0}}, ovr_q, busy};
      default:  cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctl_latch_bus.sv
module ctl_latch_bus #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4,
  localparam int REG_W = ADDR_W + DATA_W,
  localparam int FLAT_W = (1 << ADDR_W) * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              remote_mode,
  input  logic              cpu_remote,
  input  logic              cpu_wr,
  input  logic [1:0]        cpu_reg,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              rf_en,
  output logic [ADDR_W-1:0] af_addr,
  output logic [DATA_W-1:0] af_data,
  output logic              af1_en,
  output logic              af2_en,
  output logic [FLAT_W-1:0] rf_latch,
  output logic [FLAT_W-1:0] af1_latch,
  output logic [FLAT_W-1:0] af2_latch
);
  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic [2:0]        stb;
  logic              wr_op, busy;
  logic [DATA_W-1:0] rf_rd, af1_rd, af2_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  ctl_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .remote_mode(remote_mode), .cpu_remote(cpu_remote),
    .cpu_wr(cpu_wr), .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rf_rd(rf_rd), .af1_rd(af1_rd), .af2_rd(af2_rd),
    .rf_addr(rf_addr), .rf_data(rf_data), .af_addr(af_addr), .af_data(af_data),
    .stb(stb), .wr_op(wr_op), .busy(busy)
  );

  ctl_latch_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf_bank (
    .clk(clk), .rst_n(rst_n_s), .stb(stb[0]), .wr(wr_op), .addr(rf_addr),
    .wdata(rf_data), .rdata(rf_rd), .flat(rf_latch)
  );

  ctl_latch_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_af1_bank (
    .clk(clk), .rst_n(rst_n_s), .stb(stb[1]), .wr(wr_op), .addr(af_addr),
    .wdata(af_data), .rdata(af1_rd), .flat(af1_latch)
  );

  ctl_latch_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_af2_bank (
    .clk(clk), .rst_n(rst_n_s), .stb(stb[2]), .wr(wr_op), .addr(af_addr),
    .wdata(af_data), .rdata(af2_rd), .flat(af2_latch)
  );

  assign rf_en  = stb[0];
  assign af1_en = stb[1];
  assign af2_en = stb[2];
endmodule

// File: rtl/ctl_bus_chk.sv
module ctl_bus_chk #(
  parameter int AW = 4,
  parameter int DW = 4,
  parameter int FW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rf_en,
  input logic          af1_en,
  input logic          af2_en,
  input logic [AW-1:0] rf_addr,
  input logic [DW-1:0] rf_data,
  input logic [AW-1:0] af_addr,
  input logic [DW-1:0] af_data,
  input logic          busy,
  input logic [FW-1:0] rf_flat,
  input logic [FW-1:0] af2_flat
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_en, af1_en, af2_en})); // R5
  AST_RF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |=> !rf_en); // R3
  AST_AF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (af1_en || af2_en) |=> !(af1_en || af2_en)); // R3
  AST_RF_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> ($stable(rf_addr) && $stable(rf_data))); // R3
  AST_RF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |=> ($stable(rf_addr) && $stable(rf_data))); // R3
  AST_AF_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (af1_en || af2_en) |-> ($stable(af_addr) && $stable(af_data))); // R3
  AST_AF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (af1_en || af2_en) |=> ($stable(af_addr) && $stable(af_data))); // R3
  AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_en || af1_en || af2_en) |-> busy); // R3
  AST_AF2_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    !af2_en |=> $stable(af2_flat)); // R5
  AST_RF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_en |=> $stable(rf_flat)); // R4
endmodule

bind ctl_latch_bus ctl_bus_chk #(.AW(ADDR_W), .DW(DATA_W), .FW(FLAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .rf_en(rf_en), .af1_en(af1_en), .af2_en(af2_en),
  .rf_addr(rf_addr), .rf_data(rf_data), .af_addr(af_addr), .af_data(af_data),
  .busy(busy), .rf_flat(rf_latch), .af2_flat(af2_latch)
);

// File: tb/test_ctl_latch_bus.sv
module test_ctl_latch_bus;
  logic        clk, rst_n, remote_mode, cpu_remote, cpu_wr;
  logic [1:0]  cpu_reg;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic [3:0]  rf_addr, rf_data, af_addr, af_data;
  logic        rf_en, af1_en, af2_en;
  logic [63:0] rf_latch, af1_latch, af2_latch;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ctl_latch_bus i_ctl_latch_bus (
    .clk(clk), .rst_n(rst_n), .remote_mode(remote_mode), .cpu_remote(cpu_remote),
    .cpu_wr(cpu_wr), .cpu_reg(cpu_reg), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rf_addr(rf_addr), .rf_data(rf_data), .rf_en(rf_en),
    .af_addr(af_addr), .af_data(af_data), .af1_en(af1_en), .af2_en(af2_en),
    .rf_latch(rf_latch), .af1_latch(af1_latch), .af2_latch(af2_latch)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // vector: {sel[1:0], rd, 1'b0, addr[3:0], data[3:0], exp[3:0]}
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 4'h3, 4'hA, 4'h0},
    {2'd1, 1'b0, 1'b0, 4'h3, 4'h5, 4'h0},
    {2'd2, 1'b0, 1'b0, 4'h3, 4'hC, 4'h0},
    {2'd0, 1'b1, 1'b0, 4'h3, 4'h0, 4'hA},
    {2'd1, 1'b1, 1'b0, 4'h3, 4'h0, 4'h5},
    {2'd2, 1'b1, 1'b0, 4'h3, 4'h0, 4'hC},
    {2'd1, 1'b0, 1'b0, 4'hF, 4'h7, 4'h0},
    {2'd1, 1'b1, 1'b0, 4'hF, 4'h0, 4'h7},
    {2'd2, 1'b1, 1'b0, 4'hF, 4'h0, 4'h0},
    {2'd0, 1'b0, 1'b0, 4'h0, 4'h1, 4'h0},
    {2'd0, 1'b1, 1'b0, 4'h0, 4'h0, 4'h1},
    {2'd0, 1'b1, 1'b0, 4'hF, 4'h0, 4'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] r, input logic [7:0] d, input logic rem);
    cpu_reg = r; cpu_wdata = d; cpu_remote = rem; cpu_wr = 1;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 0; cpu_remote = 0;
  endtask

  task automatic read_reg(input logic [1:0] r, output logic [7:0] v);
    cpu_reg = r;
    #0.5;
    v = cpu_rdata;
  endtask

  task automatic xfer(input logic [1:0] sel, input logic rd, input logic [3:0] a,
                      input logic [3:0] d, input logic [3:0] exp);
    logic [7:0] st;
    logic [2:0] en_exp;
    logic [3:0] ba, bd;
    en_exp = 3'b001 << sel;
    cpu_write(2'd0, {d, a}, 1'b0);
    cpu_write(2'd1, {5'b0, rd, sel}, 1'b0);
    // setup cycle
    read_reg(2'd2, st);
    chk(st[0] == 1'b1, "R3 busy in setup", st[0], 1);
    chk({af2_en, af1_en, rf_en} == 3'b000, "R3 no enable in setup", {af2_en, af1_en, rf_en}, 0);
    ba = (sel == 2'd0) ? rf_addr : af_addr;
    bd = (sel == 2'd0) ? rf_data : af_data;
    chk(ba == a, "R1 address field on bus", ba, a);
    if (!rd) chk(bd == d, "R1 data field on bus", bd, d);
    @(negedge clk);
    chk({af2_en, af1_en, rf_en} == en_exp, "R5 selected enable only", {af2_en, af1_en, rf_en}, en_exp);
    @(negedge clk);
    chk({af2_en, af1_en, rf_en} == 3'b000, "R3 enable one cycle", {af2_en, af1_en, rf_en}, 0);
    ba = (sel == 2'd0) ? rf_addr : af_addr;
    chk(ba == a, "R3 address hold", ba, a);
    read_reg(2'd2, st);
    chk(st[0] == 1'b1, "R3 busy in hold", st[0], 1);
    if (rd) chk(st[7:4] == exp, "R6 readback nibble", st[7:4], exp);
    else begin
      case (sel)
        2'd0: chk(rf_latch[a*4 +: 4] == d, "R4 radio latch write", rf_latch[a*4 +: 4], d);
        2'd1: chk(af1_latch[a*4 +: 4] == d, "R5 audio1 latch write", af1_latch[a*4 +: 4], d);
        default: chk(af2_latch[a*4 +: 4] == d, "R5 audio2 latch write", af2_latch[a*4 +: 4], d);
      endcase
    end
    @(negedge clk);
    read_reg(2'd2, st);
    chk(st[0] == 1'b0, "R3 busy clears", st[0], 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, saved;
    logic [63:0] af1_snap, rf_snap;
    rst_n = 0; remote_mode = 0; cpu_remote = 0; cpu_wr = 0; cpu_reg = 0; cpu_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R7 reset state
    chk(rf_latch == 0 && af1_latch == 0 && af2_latch == 0, "R7 latches zero", rf_latch | af1_latch | af2_latch, 0);
    chk({af2_en, af1_en, rf_en} == 0, "R7 enables low", {af2_en, af1_en, rf_en}, 0);
    read_reg(2'd2, v);
    chk(v == 0, "R7 R10 status zero", v, 0);

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      af1_snap = af1_latch;
      xfer(VEC[i][15:14], VEC[i][13], VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);
      if (VEC[i][15:14] == 2'd2)
        chk(af1_latch == af1_snap, "R5 audio1 untouched by audio2", af1_latch, af1_snap);
    end
    chk(af2_latch[3*4 +: 4] == 4'hC, "R5 audio2 keeps own value", af2_latch[3*4 +: 4], 4'hC);

    // R1 command register readback
    cpu_write(2'd0, 8'h6B, 1'b0);
    read_reg(2'd0, v);
    chk(v == 8'h6B, "R1 command readback", v, 8'h6B);

    // R2 bus code 3 starts nothing
    cpu_write(2'd1, 8'h03, 1'b0);
    read_reg(2'd2, v);
    chk(v[0] == 1'b0, "R2 code 3 not busy", v[0], 0);
    chk({af2_en, af1_en, rf_en} == 0, "R2 code 3 no enable", {af2_en, af1_en, rf_en}, 0);
    @(negedge clk);
    chk({af2_en, af1_en, rf_en} == 0, "R2 code 3 no enable later", {af2_en, af1_en, rf_en}, 0);

    // R8 overrun
    cpu_write(2'd0, 8'h21, 1'b0);
    cpu_write(2'd1, 8'h00, 1'b0);
    cpu_write(2'd0, 8'h99, 1'b0);
    repeat (3) @(negedge clk);
    read_reg(2'd0, v);
    chk(v == 8'h21, "R8 busy write ignored", v, 8'h21);
    chk(rf_latch[1*4 +: 4] == 4'h2, "R8 transfer completes", rf_latch[1*4 +: 4], 4'h2);
    read_reg(2'd2, v);
    chk(v[1] == 1'b1, "R8 overrun set", v[1], 1);
    cpu_write(2'd2, 8'h00, 1'b0);
    read_reg(2'd2, v);
    chk(v[1] == 1'b0, "R8 overrun cleared", v[1], 0);

    // R9 remote mode
    remote_mode = 1;
    read_reg(2'd0, saved);
    cpu_write(2'd0, 8'h5A, 1'b0);
    read_reg(2'd0, v);
    chk(v == saved, "R9 local write ignored", v, saved);
    rf_snap = rf_latch;
    cpu_write(2'd1, 8'h00, 1'b0);
    read_reg(2'd2, v);
    chk(v[0] == 1'b0, "R9 local launch ignored", v[0], 0);
    cpu_write(2'd0, 8'h5A, 1'b1);
    read_reg(2'd0, v);
    chk(v == 8'h5A, "R9 remote write accepted", v, 8'h5A);
    cpu_write(2'd1, 8'h00, 1'b1);
    repeat (3) @(negedge clk);
    chk(rf_latch[10*4 +: 4] == 4'h5, "R9 remote transfer", rf_latch[10*4 +: 4], 4'h5);
    remote_mode = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule